// File: doc/BRIEF.md
# Page Write Buffer and Commit Sequencer

This block sits behind a serial memory's protocol engine and collects the data bytes of one page-write transaction. The engine first loads a start address. It then hands over each accepted byte. Each byte goes into a 256-entry page buffer at the current in-page offset, and a per-offset valid mask records which offsets were touched. When the transaction closes with a valid write trigger, the block commits the touched bytes to an external synchronous byte array. It keeps `busy` high for the whole program-and-write sequence, and no untouched location in the page is written.

The same block owns the internal address counter. During a write transaction the counter advances only inside the page, so roll-over overwrites earlier bytes of the same transaction. Sequential reads step the full counter across page boundaries. The array holds 512 pages of 256 bytes, and the page number is address bits 16..8. The write time is a parameter in clock cycles.

Top module: `page_commit_unit`

## Requirements
- R1: After a synchronous reset, `busy` and `mem_we` are 0 and `addr_ptr` is 0.
- R2: `addr_load` sets `addr_ptr` to `addr_in`. Each `byte_acc` stores `byte_in` at offset `addr_ptr[7:0]` and increments only bits 7..0, which wrap from 255 to 0. Bits 16..8 (the page) stay unchanged.
- R3: Bytes sent past offset 255 continue at offset 0 of the same page. A later byte to an offset replaces the earlier one, and each offset is written to the array at most once per commit.
- R4: A `commit` pulse while idle with at least one buffered byte raises `busy` in the next cycle. `busy` then stays high for exactly WRITE_TICKS + H + 3 cycles, where H is the highest buffered offset.
- R5: A commit issues one array write per buffered offset, in ascending offset order, carrying the last byte stored there. All these writes go to the page in `addr_ptr[16:8]`, and offsets that were not loaded are not written.
- R6: Array writes happen only while `busy` is high. The last write is presented in the final busy cycle, so it retires at the same clock edge where `busy` falls.
- R7: A `commit` pulse with no buffered bytes is ignored: `busy` stays low and no array write occurs.
- R8: When the commit finishes, `addr_ptr` points to the in-page offset after the last accepted byte.
- R9: The buffer is emptied by a finished commit, so a second `commit` with no new bytes is ignored.
- R10: While `busy` is high, `addr_load`, `byte_acc`, `rd_step` and `commit` have no effect on `addr_ptr`, the buffer or the array.
- R11: `rd_step` while idle increments the full 17-bit `addr_ptr`, crossing page boundaries and wrapping from 0x1FFFF to 0.
- R12: A single-byte write is a commit with one buffered byte: exactly one array location changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_load | input | 1 | Load the address counter from `addr_in` |
| addr_in | input | 17 | Start address of a transaction |
| byte_acc | input | 1 | One accepted data byte on `byte_in` |
| byte_in | input | 8 | Data byte |
| commit | input | 1 | Write trigger from the protocol engine |
| rd_step | input | 1 | Advance the address counter after a read byte |
| busy | output | 1 | Write cycle in progress |
| addr_ptr | output | 17 | Internal address counter |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | 17 | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
The bench sends a transaction of 260 bytes that starts two bytes before the end of a page. A design that carried into the page bits would write outside the page or skip offsets, and one that did not let later bytes win would leave stale data at the first offsets. A sparse transaction goes into a page that was filled beforehand, so a design that wrote the whole page shows corrupted neighbours.

The exact length of `busy` is measured for several highest offsets. A sequencer that dropped `busy` early, or kept it one cycle too long past the last write, gives the wrong count. Empty triggers, repeated triggers and traffic injected while `busy` is high all catch a design that starts a write with nothing buffered or that lets the counter drift during the cycle. Read stepping across a page boundary and past the top address checks the counter's full-width mode.

// File: rtl/pcu_pkg.sv
`timescale 1ns/1ps
package pcu_pkg;
  // Commit sequencer phases
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_HOLD  = 2'd1,
    SQ_SCAN  = 2'd2,
    SQ_DRAIN = 2'd3
  } seq_state_t;

  // Register stages between the buffer read address and the array strobe
  localparam int unsigned DRAIN_STAGES = 2;
endpackage

// File: rtl/pcu_addr_ctr.sv
`timescale 1ns/1ps
module pcu_addr_ctr #(
  parameter int ADDR_W = 17,
  parameter int OFS_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_en,
  input  logic [ADDR_W-1:0] ld_val,
  input  logic              ofs_inc,
  input  logic              lin_inc,
  output logic [ADDR_W-1:0] ptr
);
  localparam int PAGE_W = ADDR_W - OFS_W;

  logic [OFS_W-1:0]  ofs_q;
  logic [PAGE_W-1:0] page_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ofs_q  <= '0;
      page_q <= '0;
    end else if (ld_en) begin
      {page_q, ofs_q} <= ld_val;
    end else if (ofs_inc) begin
      ofs_q <= ofs_q + 1'b1;
    end else if (lin_inc) begin
      {page_q, ofs_q} <= {page_q, ofs_q} + 1'b1;
    end
  end

  assign ptr = {page_q, ofs_q};

  // R2
  ofs_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (ofs_inc && !ld_en && (&ofs_q)) |=> (ofs_q == '0 && $stable(page_q)));

  // R11
  lin_step_chk: assert property (@(posedge clk) disable iff (rst)
    (lin_inc && !ld_en && !ofs_inc) |=> (ptr == ADDR_W'($past(ptr) + 1'b1)));
endmodule

// File: rtl/pcu_page_buf.sv
`timescale 1ns/1ps
module pcu_page_buf #(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_idx,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [$clog2(DEPTH)-1:0] rd_idx,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     rd_vld,
  input  logic                     clr,
  output logic                     any_vld,
  output logic [$clog2(DEPTH)-1:0] hi_idx
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [DATA_W-1:0] store [DEPTH];
  logic [DEPTH-1:0]  mask_q;

  // Simple dual-port storage: one write port, one registered read port
  always_ff @(posedge clk) begin
    if (wr_en) store[wr_idx] <= wr_data;
    rd_data <= store[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      mask_q <= '0;
    end else if (wr_en) begin
      mask_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_vld <= 1'b0;
    else     rd_vld <= mask_q[rd_idx];
  end

  // Highest touched offset bounds the scan
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      any_vld <= 1'b0;
      hi_idx  <= '0;
    end else if (wr_en) begin
      any_vld <= 1'b1;
      if (!any_vld || wr_idx > hi_idx) hi_idx <= wr_idx;
    end
  end

  // R3
  hi_cover_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !clr) |=> (hi_idx >= $past(wr_idx) && any_vld));

  // R9
  clr_empty_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!any_vld && mask_q == '0));

  logic [IDX_W-1:0] unused_guard;
  assign unused_guard = '0;
endmodule

// File: rtl/pcu_commit_seq.sv
`timescale 1ns/1ps
module pcu_commit_seq
  import pcu_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int OFS_W       = 8,
  parameter int DATA_W      = 8,
  parameter int WRITE_TICKS = 40
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      trig,
  input  logic                      any_vld,
  input  logic [OFS_W-1:0]          hi_idx,
  input  logic [ADDR_W-OFS_W-1:0]   page,
  input  logic [DATA_W-1:0]         buf_q,
  input  logic                      buf_vld,
  output logic [OFS_W-1:0]          scan_idx,
  output logic                      finish,
  output logic                      busy,
  output logic                      mem_we,
  output logic [ADDR_W-1:0]         mem_addr,
  output logic [DATA_W-1:0]         mem_wdata
);
  localparam int TMR_W = (WRITE_TICKS < 2) ? 1 : $clog2(WRITE_TICKS);
  localparam int DRN_W = $clog2(DRAIN_STAGES);

  seq_state_t       state;
  logic [TMR_W-1:0] tmr;
  logic [OFS_W-1:0] idx;
  logic [DRN_W-1:0] drn;
  logic             s1_live;
  logic [OFS_W-1:0] s1_idx;

  assign scan_idx = idx;
  assign finish   = (state == SQ_DRAIN) && (drn == DRN_W'(DRAIN_STAGES - 1));

  // Write pipeline: buffer read -> staged offset -> registered array strobe
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_live   <= 1'b0;
      s1_idx    <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      s1_live   <= (state == SQ_SCAN);
      s1_idx    <= idx;
      mem_we    <= s1_live & buf_vld;
      mem_addr  <= {page, s1_idx};
      mem_wdata <= buf_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SQ_IDLE;
      busy  <= 1'b0;
      tmr   <= '0;
      idx   <= '0;
      drn   <= '0;
    end else begin
      case (state)
        SQ_IDLE: begin
          if (trig && any_vld) begin
            state <= SQ_HOLD;
            busy  <= 1'b1;
            tmr   <= '0;
          end
        end
        SQ_HOLD: begin
          if (tmr == TMR_W'(WRITE_TICKS - 1)) begin
            state <= SQ_SCAN;
            idx   <= '0;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        SQ_SCAN: begin
          if (idx == hi_idx) begin
            state <= SQ_DRAIN;
            drn   <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        SQ_DRAIN: begin
          if (finish) begin
            state <= SQ_IDLE;
            busy  <= 1'b0;
          end else begin
            drn <= drn + 1'b1;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  // R6
  write_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);

  // R4
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(trig) && $past(any_vld)));

  // R7
  empty_trig_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && trig && !any_vld) |=> !busy);
endmodule

// File: rtl/page_commit_unit.sv
`timescale 1ns/1ps
module page_commit_unit #(
  parameter int ADDR_W      = 17,
  parameter int OFS_W       = 8,
  parameter int DATA_W      = 8,
  parameter int WRITE_TICKS = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              byte_acc,
  input  logic [DATA_W-1:0] byte_in,
  input  logic              commit,
  input  logic              rd_step,
  output logic              busy,
  output logic [ADDR_W-1:0] addr_ptr,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  localparam int PAGE_BYTES = 1 << OFS_W;
  localparam int PAGE_W     = ADDR_W - OFS_W;

  logic              ld_en, store_en, step_en, trig_en;
  logic [OFS_W-1:0]  scan_idx, hi_idx;
  logic [DATA_W-1:0] buf_q;
  logic              buf_vld, any_vld, finish;

  // Engine requests are dropped while a write cycle runs
  assign ld_en    = addr_load & ~busy;
  assign store_en = byte_acc  & ~busy;
  assign step_en  = rd_step   & ~busy;
  assign trig_en  = commit    & ~busy;

  pcu_addr_ctr #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_ctr (
    .clk     (clk),
    .rst     (rst),
    .ld_en   (ld_en),
    .ld_val  (addr_in),
    .ofs_inc (store_en),
    .lin_inc (step_en),
    .ptr     (addr_ptr)
  );

  pcu_page_buf #(.DEPTH(PAGE_BYTES), .DATA_W(DATA_W)) u_buf (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (store_en),
    .wr_idx  (addr_ptr[OFS_W-1:0]),
    .wr_data (byte_in),
    .rd_idx  (scan_idx),
    .rd_data (buf_q),
    .rd_vld  (buf_vld),
    .clr     (finish),
    .any_vld (any_vld),
    .hi_idx  (hi_idx)
  );

  pcu_commit_seq #(
    .ADDR_W(ADDR_W), .OFS_W(OFS_W), .DATA_W(DATA_W), .WRITE_TICKS(WRITE_TICKS)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .trig      (trig_en),
    .any_vld   (any_vld),
    .hi_idx    (hi_idx),
    .page      (addr_ptr[ADDR_W-1:OFS_W]),
    .buf_q     (buf_q),
    .buf_vld   (buf_vld),
    .scan_idx  (scan_idx),
    .finish    (finish),
    .busy      (busy),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
  );

  // Observation of the previous write offset within one commit
  logic             seen_wr;
  logic [OFS_W-1:0] last_wr_ofs;
  always_ff @(posedge clk) begin
    if (rst) begin
      seen_wr     <= 1'b0;
      last_wr_ofs <= '0;
    end else if (mem_we) begin
      seen_wr     <= 1'b1;
      last_wr_ofs <= mem_addr[OFS_W-1:0];
    end else if (!busy) begin
      seen_wr <= 1'b0;
    end
  end

  // R5
  ascending_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we && seen_wr) |-> (mem_addr[OFS_W-1:0] > last_wr_ofs));

  // R5
  same_page_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr[ADDR_W-1:OFS_W] == addr_ptr[ADDR_W-1:OFS_W]));

  // R10
  ptr_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(addr_ptr));

  // R9
  drained_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !any_vld);

  logic [PAGE_W-1:0] unused_page;
  assign unused_page = '0;
endmodule

// File: tb/page_commit_unit_tb_top.sv
`timescale 1ns/1ps
module page_commit_unit_tb_top;
  localparam int AW    = 17;
  localparam int TICKS = 40;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          addr_load = 1'b0, byte_acc = 1'b0, commit = 1'b0, rd_step = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [7:0]    byte_in = '0;
  logic          busy, mem_we;
  logic [AW-1:0] addr_ptr, mem_addr;
  logic [7:0]    mem_wdata;

  int n_chk = 0, n_fail = 0, wr_cnt = 0;
  logic [7:0] arr [logic [AW-1:0]];

  always #5 clk = ~clk;

  page_commit_unit #(.WRITE_TICKS(TICKS)) dut_i (
    .clk(clk), .rst(rst), .addr_load(addr_load), .addr_in(addr_in),
    .byte_acc(byte_acc), .byte_in(byte_in), .commit(commit), .rd_step(rd_step),
    .busy(busy), .addr_ptr(addr_ptr), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata)
  );

  // Array model
  always @(posedge clk) begin
    if (mem_we) begin
      arr[mem_addr] = mem_wdata;
      wr_cnt++;
    end
  end

  function automatic int rd_arr(input logic [AW-1:0] a);
    if (arr.exists(a)) return int'(arr[a]);
    return 0;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic load_addr(input logic [AW-1:0] a);
    addr_load = 1'b1; addr_in = a;
    @(negedge clk);
    addr_load = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d);
    byte_acc = 1'b1; byte_in = d;
    @(negedge clk);
    byte_acc = 1'b0;
  endtask

  task automatic step_rd();
    rd_step = 1'b1;
    @(negedge clk);
    rd_step = 1'b0;
  endtask

  task automatic run_commit(output int len);
    commit = 1'b1;
    @(negedge clk);
    commit = 1'b0;
    len = 0;
    for (int g = 0; g < 2000 && busy; g++) begin
      len++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk("R1 busy after reset", int'(busy), 0);
    chk("R1 mem_we after reset", int'(mem_we), 0);
    chk("R1 addr_ptr after reset", int'(addr_ptr), 0);
  endtask

  task automatic t_byte_write();
    int len, w0;
    load_addr(17'h01234);
    chk("R2 ptr after load", int'(addr_ptr), 'h1234);
    send_byte(8'hA5);
    chk("R2 ptr after one byte", int'(addr_ptr), 'h1235);
    w0 = wr_cnt;
    run_commit(len);
    chk("R12 busy length single byte", len, TICKS + 'h34 + 3);
    chk("R12 one location written", wr_cnt - w0, 1);
    chk("R6 last write retired when busy fell", rd_arr(17'h01234), 'hA5);
    chk("R8 ptr after byte write", int'(addr_ptr), 'h1235);
  endtask

  task automatic t_sparse();
    int len, w0, mism;
    logic [AW-1:0] base;
    logic [7:0] expv;
    base = {9'h1F5, 8'h00};
    for (int i = 0; i < 256; i++) arr[base + AW'(i)] = 8'(i) ^ 8'h5A;
    load_addr(base + 17'h80);
    for (int k = 0; k < 5; k++) send_byte(8'hC0 + 8'(k));
    load_addr(base + 17'h10);
    for (int k = 0; k < 3; k++) send_byte(8'h20 + 8'(k));
    w0 = wr_cnt;
    run_commit(len);
    chk("R4 busy length sparse", len, TICKS + 'h84 + 3);
    chk("R5 writes only buffered offsets", wr_cnt - w0, 8);
    mism = 0;
    for (int i = 0; i < 256; i++) begin
      expv = 8'(i) ^ 8'h5A;
      if (i >= 'h80 && i <= 'h84) expv = 8'hC0 + 8'(i - 'h80);
      if (i >= 'h10 && i <= 'h12) expv = 8'h20 + 8'(i - 'h10);
      if (rd_arr(base + AW'(i)) != int'(expv)) mism++;
    end
    chk("R5 page contents after sparse commit", mism, 0);
    chk("R8 ptr after sparse commit", int'(addr_ptr), int'(base) + 'h13);
  endtask

  task automatic t_rollover();
    int len, w0, mism;
    logic [AW-1:0] base;
    logic [7:0] exp_pg [256];
    base = {9'h0AB, 8'h00};
    for (int i = 0; i < 256; i++) exp_pg[i] = 8'h00;
    load_addr(base + 17'hFE);
    for (int k = 0; k < 260; k++) begin
      send_byte(8'(k) ^ 8'h3C);
      exp_pg[(254 + k) % 256] = 8'(k) ^ 8'h3C;
    end
    chk("R3 ptr wraps inside page", int'(addr_ptr), int'(base) + 'h02);
    w0 = wr_cnt;
    run_commit(len);
    chk("R4 busy length full page", len, TICKS + 255 + 3);
    chk("R3 one write per offset", wr_cnt - w0, 256);
    mism = 0;
    for (int i = 0; i < 256; i++)
      if (rd_arr(base + AW'(i)) != int'(exp_pg[i])) mism++;
    chk("R3 later bytes win after roll-over", mism, 0);
    chk("R3 next page untouched", int'(arr.exists(base + 17'h100)), 0);
    chk("R8 ptr after roll-over commit", int'(addr_ptr), int'(base) + 'h02);
  endtask

  task automatic t_empty_and_repeat();
    int len, w0;
    w0 = wr_cnt;
    run_commit(len);
    chk("R9 second commit ignored", len, 0);
    load_addr(17'h00700);
    run_commit(len);
    repeat (4) @(negedge clk);
    chk("R7 empty trigger keeps busy low", len + int'(busy), 0);
    chk("R7 empty trigger writes nothing", wr_cnt - w0, 0);
    chk("R7 ptr unchanged by empty trigger", int'(addr_ptr), 'h700);
  endtask

  task automatic t_busy_ignored();
    int len, w0;
    load_addr(17'h03C07);
    send_byte(8'h77);
    w0 = wr_cnt;
    commit = 1'b1;
    @(negedge clk);
    commit = 1'b0;
    len = 0;
    for (int c = 0; c < 2000 && busy; c++) begin
      len++;
      if (c == 5) begin
        addr_load = 1'b1; addr_in = 17'h10000; byte_acc = 1'b1;
        byte_in = 8'h99; rd_step = 1'b1; commit = 1'b1;
      end else begin
        addr_load = 1'b0; byte_acc = 1'b0; rd_step = 1'b0; commit = 1'b0;
      end
      @(negedge clk);
    end
    addr_load = 1'b0; byte_acc = 1'b0; rd_step = 1'b0; commit = 1'b0;
    chk("R10 busy length unaffected", len, TICKS + 7 + 3);
    chk("R10 ptr unaffected while busy", int'(addr_ptr), 'h3C08);
    chk("R10 no extra writes", wr_cnt - w0, 1);
    chk("R10 data written", rd_arr(17'h03C07), 'h77);
    run_commit(len);
    chk("R10 byte during busy not buffered", len, 0);
    chk("R10 injected location untouched", int'(arr.exists(17'h10000)), 0);
  endtask

  task automatic t_read_step();
    load_addr(17'h004FF);
    step_rd();
    chk("R11 step crosses page", int'(addr_ptr), 'h500);
    load_addr(17'h1FFFE);
    step_rd();
    chk("R11 step to top", int'(addr_ptr), 'h1FFFF);
    step_rd();
    chk("R11 wrap to zero", int'(addr_ptr), 0);
    step_rd();
    chk("R11 step after wrap", int'(addr_ptr), 1);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_byte_write();
    t_sparse();
    t_rollover();
    t_empty_and_repeat();
    t_busy_ignored();
    t_read_step();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule